// File: doc/BRIEF.md
# BCD Real-Time Clock with Update-Inhibit Latch

This block keeps wall-clock time and calendar date in packed BCD and presents them to software through a small register window. Eight internal counters hold seconds, minutes, hours, day of month, day of week, month, two-digit year and century. A single-cycle strobe once per second advances them. A second copy of the same eight fields is the one software reads. It is refreshed from the counters shortly after every strobe.

Setting the inhibit bit in the control register freezes that readable copy, so a multi-byte read cannot straddle a carry. The counters keep running underneath. While frozen, software may overwrite any time field. When the bit is cleared, the written copy is pushed into the counters. Software can also program an alarm on second, minute, hour and day of month. A match raises a flag that clears when the flags register is read, and an interrupt pin follows that flag when the interrupt enable is set.

Top module: `rtcc_core`

## Requirements
- R1: After reset the time fields read 2000-01-01, weekday 01, 00:00:00 (offsets 0..7 are sec, min, hour, day of month, weekday, month, year, century), while control (offset 0xE), enables (0xC), flags (0xD) and `rdata_o` read 0x00 and `irq_o` is low.
- R2: With the inhibit bit (control bit 3) at 0, a tick advances the counters on its clock edge, and the readable fields take the new value on the following edge.
- R3: Seconds and minutes roll 59→00 with carry, hours roll 23→00, and each day rollover advances the weekday, which wraps 07→01.
- R4: Day of month wraps after 30 in months 04, 06, 09 and 11 and after 31 in the other long months. In month 02 it wraps after 29 in a leap year, otherwise after 28. A leap year has a year divisible by 4, and year 00 is leap only when the century is divisible by 4.
- R5: Year 99 rolling over sets year 00 and increments the century.
- R6: While the inhibit bit is 1, ticks leave the readable fields unchanged but still advance the counters. Clearing the bit with no field written meanwhile changes nothing until the next tick, which shows all the elapsed seconds.
- R7: A tick accepted while the inhibit bit is 0 still delivers its transfer when the bit is set in the very next cycle.
- R8: Fields written while the inhibit bit is 1 read back at once and are loaded into the counters when the bit is cleared. A tick in the clearing cycle advances the loaded value by one second.
- R9: Writes to offsets 0..7 while the inhibit bit is 0 are ignored.
- R10: Enables bit 1 arms the alarm. When a tick brings sec, min, hour and day of month (offsets 0x8..0xB) to match, flags bit 0 is set. `irq_o` is high only while that flag and enables bit 0 are both 1.
- R11: Reading the flags register returns the flag and clears it, dropping `irq_o`.
- R12: With enables bit 1 at 0, a matching time sets no flag.
- R13: Read data appears on `rdata_o` one cycle after the read strobe and holds until the next read. Unmapped offset 0xF reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 4 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Alarm interrupt |

## Verification
A wrong counter carry stays hidden while the block is frozen. It reaches the ports only as a wrong readable field two edges after the tick that caused it, and only when the inhibit bit is 0 at that tick. A stale or lost load on unfreeze therefore shows up one tick later, not when the bit is cleared. A bad alarm compare or flag clear shows on `irq_o` within one edge of the tick or the flags read. The bench runs a reference model every clock and compares both outputs on every cycle, so a corrupted field is caught on the first read that exposes it.

// File: rtl/rtcc_pkg.sv
package rtcc_pkg;

    localparam int FIELD_W  = 8;
    localparam int NUM_TIME = 8;
    localparam int NUM_ALM  = 4;

    // Field order doubles as register offset: sec at 0 up to century at 7.
    typedef struct packed {
        logic [FIELD_W-1:0] cent;
        logic [FIELD_W-1:0] year;
        logic [FIELD_W-1:0] mon;
        logic [FIELD_W-1:0] wday;
        logic [FIELD_W-1:0] mday;
        logic [FIELD_W-1:0] hour;
        logic [FIELD_W-1:0] min;
        logic [FIELD_W-1:0] sec;
    } rtcc_time_t;

    // Alarm fields share the low four positions of the time layout.
    typedef struct packed {
        logic [FIELD_W-1:0] mday;
        logic [FIELD_W-1:0] hour;
        logic [FIELD_W-1:0] min;
        logic [FIELD_W-1:0] sec;
    } rtcc_alarm_t;

    typedef logic [NUM_TIME-1:0][FIELD_W-1:0] rtcc_tvec_t;
    typedef logic [NUM_ALM-1:0][FIELD_W-1:0]  rtcc_avec_t;

    localparam logic [3:0] OFS_ENA   = 4'hC;
    localparam logic [3:0] OFS_FLAGS = 4'hD;
    localparam logic [3:0] OFS_CTRL  = 4'hE;

    localparam int INH_BIT     = 3;
    localparam int ENA_IRQ_BIT = 0;
    localparam int ENA_ALM_BIT = 1;

endpackage

// File: rtl/rtcc_calendar.sv
module rtcc_calendar
    import rtcc_pkg::*;
(
    input  rtcc_time_t cur_i,
    output rtcc_time_t nxt_o
);

    function automatic logic [FIELD_W-1:0] bcd_inc(input logic [FIELD_W-1:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return v + 8'd1;
    endfunction

    // Divisible by four in BCD: even tens digit needs units 0/4/8, odd needs 2/6.
    function automatic logic bcd_div4(input logic [FIELD_W-1:0] v);
        if (v[4]) return (v[3:0] == 4'd2) || (v[3:0] == 4'd6);
        return (v[3:0] == 4'd0) || (v[3:0] == 4'd4) || (v[3:0] == 4'd8);
    endfunction

    logic               leap;
    logic [FIELD_W-1:0] last_day;
    logic               sec_wrap, min_wrap, hour_wrap, day_wrap, mon_wrap, year_wrap;

    always_comb begin
        leap = (cur_i.year == 8'h00) ? bcd_div4(cur_i.cent) : bcd_div4(cur_i.year);
        case (cur_i.mon)
            8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
            8'h02:                      last_day = leap ? 8'h29 : 8'h28;
            default:                    last_day = 8'h31;
        endcase

        sec_wrap  = (cur_i.sec == 8'h59);
        min_wrap  = sec_wrap  && (cur_i.min  == 8'h59);
        hour_wrap = min_wrap  && (cur_i.hour == 8'h23);
        day_wrap  = hour_wrap && (cur_i.mday >= last_day);
        mon_wrap  = day_wrap  && (cur_i.mon  >= 8'h12);
        year_wrap = mon_wrap  && (cur_i.year == 8'h99);

        nxt_o     = cur_i;
        nxt_o.sec = sec_wrap ? 8'h00 : bcd_inc(cur_i.sec);
        if (sec_wrap)
            nxt_o.min = (cur_i.min == 8'h59) ? 8'h00 : bcd_inc(cur_i.min);
        if (min_wrap)
            nxt_o.hour = (cur_i.hour == 8'h23) ? 8'h00 : bcd_inc(cur_i.hour);
        if (hour_wrap) begin
            nxt_o.wday = (cur_i.wday >= 8'h07) ? 8'h01 : bcd_inc(cur_i.wday);
            nxt_o.mday = day_wrap ? 8'h01 : bcd_inc(cur_i.mday);
        end
        if (day_wrap)
            nxt_o.mon = mon_wrap ? 8'h01 : bcd_inc(cur_i.mon);
        if (mon_wrap)
            nxt_o.year = year_wrap ? 8'h00 : bcd_inc(cur_i.year);
        if (year_wrap)
            nxt_o.cent = (cur_i.cent == 8'h99) ? 8'h00 : bcd_inc(cur_i.cent);
    end

endmodule

// File: rtl/rtcc_alarm_cmp.sv
module rtcc_alarm_cmp
    import rtcc_pkg::*;
(
    input  rtcc_time_t  now_i,
    input  rtcc_alarm_t alm_i,
    output logic        hit_o
);

    rtcc_tvec_t         now_v;
    rtcc_avec_t         alm_v;
    logic [NUM_ALM-1:0] eq;

    assign now_v = rtcc_tvec_t'(now_i);
    assign alm_v = rtcc_avec_t'(alm_i);

    for (genvar i = 0; i < NUM_ALM; i++) begin : g_field
        assign eq[i] = (now_v[i] == alm_v[i]);
    end

    assign hit_o = &eq;

endmodule

// File: rtl/rtcc_core.sv
module rtcc_core
    import rtcc_pkg::*;
#(
    parameter int               ADDR_W   = 4,
    parameter logic [FIELD_W-1:0] RST_CENT = 8'h20,
    parameter logic [FIELD_W-1:0] RST_YEAR = 8'h00
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [FIELD_W-1:0] wdata_i,
    output logic [FIELD_W-1:0] rdata_o,
    output logic               irq_o
);

    localparam int TIDX_W   = $clog2(NUM_TIME);
    localparam int AIDX_W   = $clog2(NUM_ALM);
    localparam int ALM_BASE = NUM_TIME;
    localparam int ALM_END  = NUM_TIME + NUM_ALM;

    localparam rtcc_time_t RST_TIME = '{
        cent: RST_CENT, year: RST_YEAR, mon: 8'h01, wday: 8'h01,
        mday: 8'h01, hour: 8'h00, min: 8'h00, sec: 8'h00
    };

    typedef struct packed {
        rtcc_time_t         cnt;    // running counters
        rtcc_time_t         vis;    // software-visible copy
        rtcc_alarm_t        alm;
        logic               aie;
        logic               aen;
        logic               flag;
        logic               inh;    // transfer inhibit
        logic               dirty;  // visible copy written while inhibited
        logic               arm;    // transfer due on this edge
        logic               chk;    // alarm compare due on this edge
        logic [FIELD_W-1:0] rdata;
    } rtcc_state_t;

    localparam rtcc_state_t RST_STATE = '{
        cnt: RST_TIME, vis: RST_TIME, alm: '0, aie: 1'b0, aen: 1'b0,
        flag: 1'b0, inh: 1'b0, dirty: 1'b0, arm: 1'b0, chk: 1'b0, rdata: '0
    };

    rtcc_state_t        state_q, state_d;
    rtcc_time_t         cal_in, cal_nxt;
    logic               alm_hit;
    logic               wr_time, wr_ctrl, do_load;
    rtcc_tvec_t         tv_rd, tv_wr;
    rtcc_avec_t         av_rd, av_wr;
    logic [FIELD_W-1:0] rd_val;

    rtcc_calendar u_cal (
        .cur_i (cal_in),
        .nxt_o (cal_nxt)
    );

    rtcc_alarm_cmp u_cmp (
        .now_i (state_q.cnt),
        .alm_i (state_q.alm),
        .hit_o (alm_hit)
    );

    always_comb begin
        state_d = state_q;

        wr_time = wr_en_i && (int'(addr_i) < NUM_TIME);
        wr_ctrl = wr_en_i && (addr_i == OFS_CTRL);
        do_load = wr_ctrl && state_q.inh && !wdata_i[INH_BIT] && state_q.dirty;

        // Counters: one incrementer, fed by the written copy on unfreeze.
        cal_in      = do_load ? state_q.vis : state_q.cnt;
        state_d.cnt = tick_i ? cal_nxt : cal_in;

        // A tick seen while not inhibited schedules one transfer next edge.
        state_d.arm = tick_i && !state_q.inh;
        state_d.chk = tick_i;
        if (state_q.arm)
            state_d.vis = state_q.cnt;

        tv_wr = rtcc_tvec_t'(state_d.vis);
        if (wr_time && state_q.inh) begin
            tv_wr[addr_i[TIDX_W-1:0]] = wdata_i;
            state_d.dirty             = 1'b1;
        end
        state_d.vis = rtcc_time_t'(tv_wr);

        av_wr = rtcc_avec_t'(state_q.alm);
        if (wr_en_i && int'(addr_i) >= ALM_BASE && int'(addr_i) < ALM_END)
            av_wr[addr_i[AIDX_W-1:0]] = wdata_i;
        state_d.alm = rtcc_alarm_t'(av_wr);

        if (wr_en_i && addr_i == OFS_ENA) begin
            state_d.aie = wdata_i[ENA_IRQ_BIT];
            state_d.aen = wdata_i[ENA_ALM_BIT];
        end

        if (wr_ctrl) begin
            state_d.inh = wdata_i[INH_BIT];
            if (!wdata_i[INH_BIT])
                state_d.dirty = 1'b0;
        end

        // Read mux from current state.
        tv_rd  = rtcc_tvec_t'(state_q.vis);
        av_rd  = rtcc_avec_t'(state_q.alm);
        rd_val = '0;
        if (int'(addr_i) < NUM_TIME)
            rd_val = tv_rd[addr_i[TIDX_W-1:0]];
        else if (int'(addr_i) < ALM_END)
            rd_val = av_rd[addr_i[AIDX_W-1:0]];
        else if (addr_i == OFS_ENA) begin
            rd_val[ENA_IRQ_BIT] = state_q.aie;
            rd_val[ENA_ALM_BIT] = state_q.aen;
        end else if (addr_i == OFS_FLAGS)
            rd_val[0] = state_q.flag;
        else if (addr_i == OFS_CTRL)
            rd_val[INH_BIT] = state_q.inh;

        if (rd_en_i) begin
            state_d.rdata = rd_val;
            if (addr_i == OFS_FLAGS)
                state_d.flag = 1'b0;
        end

        // A new match wins over a clearing read in the same cycle.
        if (state_q.chk && state_q.aen && alm_hit)
            state_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RST_STATE;
        else        state_q <= state_d;
    end

    assign rdata_o = state_q.rdata;
    assign irq_o   = state_q.flag && state_q.aie;

endmodule

// File: rtl/rtcc_core_chk.sv
module rtcc_core_chk
    import rtcc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        tick_i,
    input logic        wr_en_i,
    input logic        rd_en_i,
    input logic [3:0]  addr_i,
    input logic        ctl_bit,
    input logic        irq_o,
    input logic        inh_q,
    input logic        arm_q,
    input logic        chk_q,
    input logic        dirty_q,
    input logic [63:0] cnt_q,
    input logic [63:0] vis_q
);

    // R2: a scheduled transfer copies the counters into the visible fields.
    a_r2_arm_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q && !wr_en_i) |=> (vis_q == $past(cnt_q)));

    // R3: seconds and hours stay in legal BCD range.
    a_r3_bcd_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q[3:0] <= 4'd9) && (cnt_q[7:0] <= 8'h59) && (cnt_q[23:16] <= 8'h23));

    // R6: while inhibited and idle, the visible copy does not move.
    a_r6_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (inh_q && !arm_q && !(wr_en_i && !addr_i[3])) |=> $stable(vis_q));

    // R6: counters keep advancing under inhibit.
    a_r6_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && inh_q && !(wr_en_i && addr_i == OFS_CTRL)) |=> (cnt_q != $past(cnt_q)));

    // R8: unfreezing a written copy loads it into the counters.
    a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == OFS_CTRL && !ctl_bit && inh_q && dirty_q && !tick_i)
        |=> (cnt_q == $past(vis_q)));

    // R11: reading the flags drops the interrupt unless a compare is due.
    a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == OFS_FLAGS && !chk_q) |=> !irq_o);

endmodule

bind rtcc_core rtcc_core_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .ctl_bit (wdata_i[3]),
    .irq_o   (irq_o),
    .inh_q   (state_q.inh),
    .arm_q   (state_q.arm),
    .chk_q   (state_q.chk),
    .dirty_q (state_q.dirty),
    .cnt_q   (state_q.cnt),
    .vis_q   (state_q.vis)
);

// File: tb/rtcc_core_bench.sv
`timescale 1ns/1ps
module rtcc_core_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wd = '0;
    logic [7:0] rdata;
    logic       irq;

    always #2 clk = ~clk;

    rtcc_core u_rtcc_core (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr), .rd_en_i(rd),
        .addr_i(addr), .wdata_i(wd), .rdata_o(rdata), .irq_o(irq)
    );

    int    errors = 0;
    int    checks = 0;
    string cur_req = "R1";

    // Reference model: decimal counters, BCD visible bytes.
    int         m_cnt [8];
    logic [7:0] m_vis [8];
    logic [7:0] m_alm [4];
    bit         m_aie, m_aen, m_flag, m_inh, m_dirty, m_arm, m_chk;
    logic [7:0] m_rdata;

    function automatic logic [7:0] to_bcd(int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    function automatic int from_bcd(logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int month_days(int mo, int y);
        bit leap = (y % 4 == 0) && ((y % 100 != 0) || (y % 400 == 0));
        if (mo == 2) return leap ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic model_reset();
        m_cnt = '{0, 0, 0, 1, 1, 1, 0, 20};
        foreach (m_vis[i]) m_vis[i] = to_bcd(m_cnt[i]);
        foreach (m_alm[i]) m_alm[i] = 8'h00;
        {m_aie, m_aen, m_flag, m_inh, m_dirty, m_arm, m_chk} = '0;
        m_rdata = 8'h00;
    endtask

    task automatic advance();
        m_cnt[0]++;
        if (m_cnt[0] == 60) begin
            m_cnt[0] = 0; m_cnt[1]++;
            if (m_cnt[1] == 60) begin
                m_cnt[1] = 0; m_cnt[2]++;
                if (m_cnt[2] == 24) begin
                    m_cnt[2] = 0;
                    m_cnt[4] = m_cnt[4] % 7 + 1;
                    m_cnt[3]++;
                    if (m_cnt[3] > month_days(m_cnt[5], m_cnt[7] * 100 + m_cnt[6])) begin
                        m_cnt[3] = 1; m_cnt[5]++;
                        if (m_cnt[5] == 13) begin
                            m_cnt[5] = 1; m_cnt[6]++;
                            if (m_cnt[6] == 100) begin
                                m_cnt[6] = 0;
                                m_cnt[7] = (m_cnt[7] + 1) % 100;
                            end
                        end
                    end
                end
            end
        end
    endtask

    function automatic logic [7:0] model_read(logic [3:0] a);
        if (a < 8)  return m_vis[a];
        if (a < 12) return m_alm[a - 8];
        if (a == 12) return {6'b0, m_aen, m_aie};
        if (a == 13) return {7'b0, m_flag};
        if (a == 14) return {4'b0, m_inh, 3'b0};
        return 8'h00;
    endfunction

    task automatic model_step();
        int         oc [8];
        logic [7:0] ov [8];
        logic [7:0] oa [4];
        bit o_inh = m_inh, o_dirty = m_dirty, o_arm = m_arm, o_chk = m_chk, o_aen = m_aen;
        bit hit;
        oc = m_cnt; ov = m_vis; oa = m_alm;
        if (rd) m_rdata = model_read(addr);
        if (wr && addr == 14 && o_inh && !wd[3] && o_dirty)
            foreach (m_cnt[i]) m_cnt[i] = from_bcd(ov[i]);
        if (tick) advance();
        if (o_arm) foreach (m_vis[i]) m_vis[i] = to_bcd(oc[i]);
        if (wr && addr < 8 && o_inh) begin m_vis[addr] = wd; m_dirty = 1; end
        if (wr && addr >= 8 && addr < 12) m_alm[addr - 8] = wd;
        if (wr && addr == 12) begin m_aie = wd[0]; m_aen = wd[1]; end
        if (wr && addr == 14) begin m_inh = wd[3]; if (!wd[3]) m_dirty = 0; end
        hit = 1;
        for (int i = 0; i < 4; i++) if (oc[i] != from_bcd(oa[i])) hit = 0;
        if (o_chk && o_aen && hit) m_flag = 1;
        else if (rd && addr == 13) m_flag = 0;
        m_arm = tick && !o_inh;
        m_chk = tick;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else        model_step();
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Cycle compare against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            check(rdata == m_rdata, cur_req, "model rdata", int'(rdata), int'(m_rdata));
            check(irq == (m_flag && m_aie), cur_req, "model irq", int'(irq), int'(m_flag && m_aie));
        end
    end

    task automatic wr_reg(logic [3:0] a, logic [7:0] d);
        @(negedge clk); wr = 1; addr = a; wd = d;
        @(negedge clk); wr = 0;
    endtask

    task automatic expect_rd(logic [3:0] a, logic [7:0] exp, string req);
        @(negedge clk); rd = 1; addr = a;
        @(negedge clk); rd = 0;
        check(rdata == exp, req, "read", int'(rdata), int'(exp));
    endtask

    task automatic tick1();
        @(negedge clk); tick = 1;
        @(negedge clk); tick = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic load_time(logic [7:0] ce, yr, mo, wdy, md, hr, mi, se);
        wr_reg(14, 8'h08);
        wr_reg(0, se); wr_reg(1, mi); wr_reg(2, hr); wr_reg(3, md);
        wr_reg(4, wdy); wr_reg(5, mo); wr_reg(6, yr); wr_reg(7, ce);
        wr_reg(14, 8'h00);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        cur_req = "R1";
        check(irq == 1'b0, "R1", "irq after reset", int'(irq), 0);
        check(rdata == 8'h00, "R1", "rdata after reset", int'(rdata), 0);
        expect_rd(0, 8'h00, "R1"); expect_rd(3, 8'h01, "R1");
        expect_rd(4, 8'h01, "R1"); expect_rd(5, 8'h01, "R1");
        expect_rd(6, 8'h00, "R1"); expect_rd(7, 8'h20, "R1");
        expect_rd(12, 8'h00, "R1"); expect_rd(13, 8'h00, "R1");
        expect_rd(14, 8'h00, "R1");

        // R2 ticks reach the visible fields
        cur_req = "R2";
        repeat (3) tick1();
        expect_rd(0, 8'h03, "R2");

        // R9 writes ignored without inhibit
        cur_req = "R9";
        wr_reg(0, 8'h45);
        expect_rd(0, 8'h03, "R9");

        // R8 / R3 / R4 leap February
        cur_req = "R8";
        load_time(8'h20, 8'h24, 8'h02, 8'h07, 8'h28, 8'h23, 8'h59, 8'h58);
        expect_rd(0, 8'h58, "R8");
        cur_req = "R3";
        tick1(); expect_rd(0, 8'h59, "R3");
        tick1(); tick1();
        expect_rd(0, 8'h01, "R3"); expect_rd(1, 8'h00, "R3");
        expect_rd(2, 8'h00, "R3"); expect_rd(4, 8'h01, "R3");
        expect_rd(3, 8'h29, "R4"); expect_rd(5, 8'h02, "R4");

        cur_req = "R4";
        load_time(8'h20, 8'h23, 8'h02, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
        tick1(); expect_rd(3, 8'h01, "R4"); expect_rd(5, 8'h03, "R4");
        load_time(8'h20, 8'h00, 8'h02, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
        tick1(); expect_rd(3, 8'h29, "R4");
        load_time(8'h21, 8'h00, 8'h02, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
        tick1(); expect_rd(3, 8'h01, "R4"); expect_rd(5, 8'h03, "R4");
        load_time(8'h20, 8'h24, 8'h04, 8'h02, 8'h30, 8'h23, 8'h59, 8'h59);
        tick1(); expect_rd(3, 8'h01, "R4"); expect_rd(5, 8'h05, "R4");

        // R5 century carry
        cur_req = "R5";
        load_time(8'h20, 8'h99, 8'h12, 8'h03, 8'h31, 8'h23, 8'h59, 8'h59);
        tick1();
        expect_rd(7, 8'h21, "R5"); expect_rd(6, 8'h00, "R5");
        expect_rd(5, 8'h01, "R5"); expect_rd(4, 8'h04, "R5");

        // R6 freeze without writes
        cur_req = "R6";
        load_time(8'h20, 8'h24, 8'h01, 8'h01, 8'h01, 8'h10, 8'h00, 8'h00);
        wr_reg(14, 8'h08);
        repeat (3) tick1();
        expect_rd(0, 8'h00, "R6");
        wr_reg(14, 8'h00);
        expect_rd(0, 8'h00, "R6");
        tick1();
        expect_rd(0, 8'h04, "R6");

        // R7 tick just before freezing still lands
        cur_req = "R7";
        @(negedge clk); tick = 1;
        @(negedge clk); tick = 0; wr = 1; addr = 14; wd = 8'h08;
        @(negedge clk); wr = 0;
        repeat (2) @(negedge clk);
        expect_rd(0, 8'h05, "R7");
        wr_reg(14, 8'h00);

        // R8 tick coinciding with unfreeze
        cur_req = "R8";
        wr_reg(14, 8'h08);
        wr_reg(0, 8'h30);
        @(negedge clk); wr = 1; addr = 14; wd = 8'h00; tick = 1;
        @(negedge clk); wr = 0; tick = 0;
        repeat (2) @(negedge clk);
        expect_rd(0, 8'h30, "R8");
        tick1();
        expect_rd(0, 8'h32, "R8");

        // R10 / R11 alarm
        cur_req = "R10";
        load_time(8'h20, 8'h24, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
        wr_reg(8, 8'h03); wr_reg(9, 8'h00); wr_reg(10, 8'h00); wr_reg(11, 8'h01);
        wr_reg(12, 8'h03);
        tick1(); tick1();
        check(irq == 1'b0, "R10", "irq before match", int'(irq), 0);
        tick1();
        check(irq == 1'b1, "R10", "irq at match", int'(irq), 1);
        cur_req = "R11";
        expect_rd(13, 8'h01, "R11");
        check(irq == 1'b0, "R11", "irq after flag read", int'(irq), 0);
        expect_rd(13, 8'h00, "R11");

        // R12 alarm disarmed
        cur_req = "R12";
        wr_reg(12, 8'h01); wr_reg(8, 8'h05);
        tick1(); tick1();
        check(irq == 1'b0, "R12", "irq disarmed", int'(irq), 0);
        expect_rd(13, 8'h00, "R12");
        cur_req = "R10";
        wr_reg(12, 8'h02); wr_reg(8, 8'h07);
        tick1(); tick1();
        check(irq == 1'b0, "R10", "irq masked", int'(irq), 0);
        expect_rd(13, 8'h01, "R10");

        // R13 latency, hold, unmapped
        cur_req = "R13";
        expect_rd(15, 8'h00, "R13");
        expect_rd(7, 8'h20, "R13");
        repeat (3) @(negedge clk);
        check(rdata == 8'h20, "R13", "rdata hold", int'(rdata), 32);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule